// File: doc/BRIEF.md
# SD Card Clock Prescaler and Divider Configurator

This block turns a requested card clock frequency into the contents of a clock-control register, given the frequency of the base clock. When a start request is accepted, the block first turns the clock off. It clears the three enable bits and the rate fields. It then searches for a power-of-two prescaler and a linear divider over several cycles. Finally it writes the fields together with the enable bits in a single update.

After the clock is enabled, the block waits a fixed settle interval before it reports completion. The length of this interval is a parameter. Its nominal value is 100 ms of core clock, and a bench can set it much shorter.

While a request runs, the block holds a timeout-clock value equal to the latched base frequency divided by 1000. A request with a target of zero leaves the clock off. Frequencies are unsigned integers in any consistent unit. All divisions in the rules below are integer divisions that round down.

Top module: `sd_clk_cfg`

## Requirements
- R1: A start request made while idle is accepted at that clock edge. From the next cycle, `sysctl_o` reads zero, with enables off and rate fields cleared. `busy_o` then stays high up to and including the cycle in which `done_o` is high.
- R2: A target of zero completes with `sysctl_o` equal to zero, so the clocks stay disabled.
- R3: The prescaler P starts at 2. Only if base/16 > target does P double repeatedly. Doubling stops at the first P for which base/P < 16·target, and P never goes above 256.
- R4: The divider D is the smallest value in 1..16 for which base/(D·P) ≤ target. If no value qualifies, D is 16.
- R5: The enabled register value is (P/2)<<8 OR D<<4 OR 7. Bits 31:16 and bit 3 are always zero.
- R6: The three enable bits 2:0 change together. They are set in the same cycle as the rate fields, so a nonzero register never has partial enables.
- R7: `done_o` rises exactly SETTLE_CYC cycles after the enable bits are set. It is high for one cycle, and `busy_o` is low in the cycle after it.
- R8: `tout_clk_o` equals the base frequency latched at acceptance divided by 1000. It holds that value while busy and after completion.
- R9: A start request made while `busy_o` is high is ignored. The running request completes with its own register value and timeout clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a reconfiguration (taken only while idle) |
| base_i | input | FW | Base clock frequency, sampled at acceptance |
| target_i | input | FW | Requested card clock frequency, sampled at acceptance |
| busy_o | output | 1 | Reconfiguration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sysctl_o | output | 32 | Clock-control register image |
| tout_clk_o | output | FW | Timeout clock, base divided by 1000 |

## Verification
The hardest case to reach is a base that is too fast for any allowed setting. In that case the prescaler reaches its cap of 256 and the divider saturates at 16. The sweep reaches it by pairing a full-scale base with very small targets. It also pairs small bases with large targets, so that the prescaler gate stays closed and the divider stops at 1. A second start is injected a few cycles into a running search to show that the request in flight is untouched. A zero target is always issued right after an enabled configuration, so that the clearing step can be seen.

// File: rtl/sdcc_pkg.sv
package sdcc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHK, ST_PRE, ST_DIV, ST_PROG, ST_SETTLE, ST_FIN
  } sdcc_st_e;

  localparam int unsigned MAX_PRE_SH = 8;   // prescaler cap 2^8
  localparam int unsigned MAX_DIV    = 16;
  localparam int unsigned GATE_SH    = 4;   // base/16 gate, 16x target
  localparam int unsigned GUARD_W    = 13;  // headroom for t*16*256
endpackage

// File: rtl/sdcc_presc.sv
module sdcc_presc
  import sdcc_pkg::*;
#(
  parameter int unsigned FW = 32,
  localparam int unsigned PW = FW + GUARD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [FW-1:0] base_i,
  input  logic [FW-1:0] tgt_i,
  output logic          gate_o,
  output logic          stop_o,
  output logic [3:0]    sh_o
);
  logic [3:0]    sh_q;
  logic [PW-1:0] base_w, tgt_w;

  assign base_w = PW'(base_i);
  assign tgt_w  = PW'(tgt_i);

  // base/16 > t  <=>  base >= 16*(t+1)
  assign gate_o = base_w >= ((tgt_w + PW'(1)) << GATE_SH);
  // base/P < 16*t  <=>  base < t << (sh+4)
  assign stop_o = (sh_q == 4'(MAX_PRE_SH)) ||
                  (base_w < (tgt_w << (sh_q + 4'(GATE_SH))));
  assign sh_o   = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= 4'd1;
    else if (load_i) sh_q <= 4'd1;
    else if (step_i) sh_q <= sh_q + 4'd1;
  end
endmodule

// File: rtl/sdcc_div.sv
module sdcc_div
  import sdcc_pkg::*;
#(
  parameter int unsigned FW = 32,
  localparam int unsigned PW = FW + GUARD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [FW-1:0] base_i,
  input  logic [FW-1:0] tgt_i,
  input  logic [3:0]    sh_i,
  output logic          stop_o,
  output logic [4:0]    div_o
);
  logic [4:0]    div_q;
  logic [PW-1:0] acc_q, inc_w, base_w;

  assign base_w = PW'(base_i);
  // base/(D*P) <= t  <=>  base < (t+1)*D*P ; acc tracks (t+1)*D*P
  assign inc_w  = (PW'(tgt_i) + PW'(1)) << sh_i;
  assign stop_o = (div_q == 5'(MAX_DIV)) || (base_w < acc_q);
  assign div_o  = div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= 5'd1;
      acc_q <= '0;
    end else if (load_i) begin
      div_q <= 5'd1;
      acc_q <= inc_w;
    end else if (step_i) begin
      div_q <= div_q + 5'd1;
      acc_q <= acc_q + inc_w;
    end
  end
endmodule

// File: rtl/sdcc_settle.sv
module sdcc_settle #(
  parameter int unsigned CYC = 4,
  localparam int unsigned CW = $clog2(CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expire_o
);
  logic [CW-1:0] cnt_q;

  assign expire_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= CW'(CYC - 1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/sd_clk_cfg.sv
module sd_clk_cfg
  import sdcc_pkg::*;
#(
  parameter int unsigned FW         = 32,
  parameter int unsigned SETTLE_CYC = 10_000_000,
  parameter int unsigned TOUT_DIV   = 1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [FW-1:0] base_i,
  input  logic [FW-1:0] target_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [31:0]   sysctl_o,
  output logic [FW-1:0] tout_clk_o
);
  sdcc_st_e      st_q;
  logic [FW-1:0] base_q, tgt_q;
  logic [15:0]   ctl_q, ctl_enc;
  logic          gate, p_stop, d_stop, expire;
  logic          p_load, p_step, d_load, d_step, t_load;
  logic [3:0]    sh;
  logic [4:0]    dv;
  logic [7:0]    pre_half;

  assign p_load = start_i && (st_q == ST_IDLE);
  assign p_step = (st_q == ST_PRE) && !p_stop;
  assign d_load = ((st_q == ST_CHK) && !gate) || ((st_q == ST_PRE) && p_stop);
  assign d_step = (st_q == ST_DIV) && !d_stop;
  assign t_load = (st_q == ST_PROG);

  sdcc_presc #(.FW(FW)) u_presc (
    .clk_i, .rst_ni, .load_i(p_load), .step_i(p_step),
    .base_i(base_q), .tgt_i(tgt_q),
    .gate_o(gate), .stop_o(p_stop), .sh_o(sh)
  );

  sdcc_div #(.FW(FW)) u_div (
    .clk_i, .rst_ni, .load_i(d_load), .step_i(d_step),
    .base_i(base_q), .tgt_i(tgt_q), .sh_i(sh),
    .stop_o(d_stop), .div_o(dv)
  );

  sdcc_settle #(.CYC(SETTLE_CYC)) u_settle (
    .clk_i, .rst_ni, .load_i(t_load), .expire_o(expire)
  );

  // field holds P/2; divider OR-ed in at bit 4; enables 2:0
  assign pre_half = 8'd1 << (sh - 4'd1);
  assign ctl_enc  = {pre_half, 8'h00} | {7'd0, dv, 4'd0} | 16'h0007;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      base_q <= '0;
      tgt_q  <= '0;
      ctl_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          base_q <= base_i;
          tgt_q  <= target_i;
          ctl_q  <= '0;
          st_q   <= (target_i == '0) ? ST_FIN : ST_CHK;
        end
        ST_CHK:    st_q <= gate ? ST_PRE : ST_DIV;
        ST_PRE:    if (p_stop) st_q <= ST_DIV;
        ST_DIV:    if (d_stop) st_q <= ST_PROG;
        ST_PROG: begin
          ctl_q <= ctl_enc;
          st_q  <= ST_SETTLE;
        end
        ST_SETTLE: if (expire) st_q <= ST_FIN;
        ST_FIN:    st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = (st_q == ST_FIN);
  assign sysctl_o   = {16'h0000, ctl_q};
  assign tout_clk_o = base_q / FW'(TOUT_DIV);
endmodule

// File: rtl/sdcc_chk.sv
module sdcc_chk #(
  parameter int unsigned FW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [31:0]   sysctl_o,
  input logic [FW-1:0] tout_clk_o
);
  // R1
  start_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && (sysctl_o == 32'd0));

  // R5
  spare_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sysctl_o[31:16] == 16'd0) && !sysctl_o[3]);

  // R6
  en_group_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sysctl_o[2:0] == 3'b000) || (sysctl_o[2:0] == 3'b111));

  // R6
  en_with_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sysctl_o[0]) |-> (sysctl_o[15:4] != 12'd0));

  // R6
  no_live_rewrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sysctl_o[0] && $past(sysctl_o[0]) |-> $stable(sysctl_o));

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  // R1
  done_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  // R8
  tout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(tout_clk_o));
endmodule

bind sd_clk_cfg sdcc_chk #(.FW(FW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .sysctl_o(sysctl_o), .tout_clk_o(tout_clk_o)
);

// File: tb/sd_clk_cfg_bench.sv
`timescale 1ns/1ps
module sd_clk_cfg_bench;
  localparam int unsigned FW = 16;
  localparam int unsigned SC = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [FW-1:0] base = '0, tgt = '0;
  logic          busy, done;
  logic [31:0]   sysctl;
  logic [FW-1:0] tout;
  int            n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  sd_clk_cfg #(.FW(FW), .SETTLE_CYC(SC), .TOUT_DIV(1000)) u_sd_clk_cfg (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base),
    .target_i(tgt), .busy_o(busy), .done_o(done), .sysctl_o(sysctl),
    .tout_clk_o(tout)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint ref_reg(input longint b, input longint t);
    longint p, d;
    if (t == 0) return 0;
    p = 2;
    if (b / 16 > t)
      while (p < 256 && !(b / p < t * 16)) p = p * 2;
    d = 1;
    while (d <= 16 && !(b / (d * p) <= t)) d = d + 1;
    if (d > 16) d = 16;
    return ((p / 2) << 8) | (d << 4) | 7;
  endfunction

  task automatic run(input longint b, input longint t, input bit poke);
    longint exp;
    int     cyc, n_en;
    bit     seen, bad6;
    exp = ref_reg(b, t);
    @(negedge clk);
    start = 1'b1; base = FW'(b); tgt = FW'(t);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1 busy", longint'(busy), 1);
    chk(sysctl == 32'd0, "R1 clear", longint'(sysctl), 0);
    cyc = 0; n_en = 0; seen = 0; bad6 = 0;
    while (cyc < 400) begin
      if (seen) n_en++;
      else if (sysctl[0]) seen = 1;
      if (sysctl != 0 && sysctl[2:0] != 3'b111) bad6 = 1;
      if (done) break;
      if (poke && cyc == 2) begin
        start = 1'b1; base = ~FW'(b); tgt = FW'(t + 3);
      end else if (poke && cyc == 3) begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    chk(cyc < 400, "R7 completion", longint'(cyc), 400);
    if (t == 0)
      chk(sysctl == 32'd0, "R2 zero target", longint'(sysctl), 0);
    else if (poke)
      chk(longint'(sysctl) == exp, "R9 ignored start", longint'(sysctl), exp);
    else
      chk(longint'(sysctl) == exp, "R3 R4 R5 register", longint'(sysctl), exp);
    chk(!bad6, "R6 partial enables", longint'(bad6), 0);
    if (t != 0) chk(n_en == SC, "R7 settle", longint'(n_en), SC);
    chk(longint'(tout) == b / 1000, poke ? "R9 tout" : "R8 tout", longint'(tout), b / 1000);
    @(negedge clk);
    chk(!done && !busy, "R7 pulse end", longint'({done, busy}), 0);
    chk(longint'(tout) == b / 1000, "R8 hold", longint'(tout), b / 1000);
  endtask

  initial begin
    #1_600_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    longint bases[6];
    bases = '{0, 100, 1000, 4096, 50000, 65535};
    repeat (3) @(negedge clk);
    // reset state
    chk(sysctl == 32'd0, "R1 reset reg", longint'(sysctl), 0);
    chk(!busy && !done, "R1 reset flags", longint'({busy, done}), 0);
    chk(tout == '0, "R8 reset tout", longint'(tout), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(48000, 400, 1'b0);
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 64; i++) begin
        longint t;
        t = (i < 32) ? longint'(i) : longint'((i * i * 17 + i * 301) % 65536);
        run(bases[k], t, 1'b0);
      end
      run(bases[k], 65535, 1'b0);
    end
    // R9 starts injected while busy
    run(65535, 1, 1'b1);
    run(50000, 7, 1'b1);
    run(1000, 3, 1'b1);
    run(65535, 2, 1'b0);
    run(65535, 0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule